// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block is the bus master that connects a small processor core to external memory over a shared 16-bit address/data bus. The core hands it a 20-bit byte address together with a read or a write request. A read returns one 16-bit instruction word. A write carries one data byte. The controller runs the external bus through a fixed sequence of phases. The address phase places the low sixteen address bits on the shared lines and raises the latch enable. The turnaround phase releases the lines. The data phase either opens the output enable or pulses a write strobe. The four upper address bits stay on their own dedicated lines for the whole access.

A 2-bit write-mode input selects how external memory takes a byte. The first option suits two byte-wide parts, each with its own high or low write strobe. The second suits word-wide parts that have a single write strobe. The third suits static RAM that uses upper and lower byte enables plus a byte-address line. In every mode the byte is copied onto both halves of the bus. A sleep input keeps chip enable inactive and blocks new accesses.

Top module: `mxbus_ctrl`

## Requirements
- R1: After reset, and in every idle cycle, the outputs hold their idle values. These are: bus_ad_en 0, ale 0, done 0, ba0 0 and addr_hi 0. The active-low strobes oe_n, wrh_n, wrl_n, wr_n, ub_n and lb_n are all 1, and ce_n is 1.
- R2: The controller accepts a request on the clock edge where it is idle, sleep_i is 0 and req_rd or req_wr is 1. In the next cycle (the address cycle) ale is 1, bus_ad_en is 1 and bus_ad_out equals req_addr[15:0]. addr_hi equals req_addr[19:16] in all three access cycles.
- R3: The cycle after the address cycle is the turnaround cycle. In it ale is 0, bus_ad_en is 0, and oe_n, wrh_n, wrl_n and wr_n are all 1.
- R4: In the data cycle of a read, oe_n, ub_n and lb_n are 0, bus_ad_en is 0 and all write strobes are 1. The controller captures bus_ad_in at the end of that cycle. In the following cycle rd_data holds the captured word and done is 1. Done lasts exactly one cycle, for reads and writes alike.
- R5: ce_n is 0 in the address, turnaround and data cycles of every access made while sleep_i is 0.
- R6: With wr_mode 2'b00 (byte write), the data cycle of a write behaves as follows. bus_ad_out equals {byte, byte} and bus_ad_en is 1. Only wrh_n goes to 0 when the address LSB is 1, and only wrl_n goes to 0 when it is 0. ub_n, lb_n and wr_n stay 1, and ba0 stays 0.
- R7: With wr_mode 2'b01 (word write), the data cycle of a write drives {byte, byte} and sets wr_n, ub_n and lb_n to 0. wrh_n and wrl_n stay 1, and ba0 stays 0.
- R8: With wr_mode 2'b10 or 2'b11 (byte select), the data cycle of a write drives {byte, byte} and sets wr_n to 0. ub_n goes to 0 alone when the address LSB is 1, and lb_n goes to 0 alone when it is 0. ba0 equals the address LSB in all three access cycles.
- R9: While sleep_i is 1, ce_n is 1, and the controller ignores requests: no ale, no done, and external memory is left unchanged.
- R10: When req_rd and req_wr are both 1 in the accepting cycle, the controller performs a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_rd | input | 1 | Read request |
| req_wr | input | 1 | Write request |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 8 | Byte to write |
| wr_mode | input | 2 | Write scheme: 00 byte write, 01 word write, 1x byte select |
| sleep_i | input | 1 | Sleep: chip enable off, requests ignored |
| bus_ad_in | input | 16 | Value read from the shared address/data lines |
| rd_data | output | 16 | Captured instruction word |
| done | output | 1 | One-cycle pulse at the end of an access |
| bus_ad_out | output | 16 | Value driven onto the shared address/data lines |
| bus_ad_en | output | 1 | Output enable of the shared-line driver |
| addr_hi | output | 4 | Upper address bits 19..16 |
| ale | output | 1 | Address latch enable, active high |
| oe_n | output | 1 | Output enable, active low |
| ce_n | output | 1 | Chip enable, active low |
| wrh_n | output | 1 | High-byte write strobe, active low |
| wrl_n | output | 1 | Low-byte write strobe, active low |
| wr_n | output | 1 | Single word write strobe, active low |
| ub_n | output | 1 | Upper byte enable, active low |
| lb_n | output | 1 | Lower byte enable, active low |
| ba0 | output | 1 | Byte address line for byte-select memories |

## Verification
Directed writes in every mode use both address parities, and a read-back follows each one. This separates which strobe or byte enable fired from which memory lane changed. Random sequences mix reads and writes across all four mode codes and reuse addresses. They show whether a later write in a different mode corrupts the lane it should leave alone. Simultaneous read and write requests show the read priority. Requests made during sleep are followed by a read of the same location, which proves that nothing reached memory.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_TURN = 2'd2,
        PH_DATA = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        WM_BYTE  = 2'b00,
        WM_WORD  = 2'b01,
        WM_BSEL  = 2'b10,
        WM_BSEL2 = 2'b11
    } wmode_t;

    typedef struct packed {
        logic ale;
        logic drive;
        logic oe_n;
        logic wrh_n;
        logic wrl_n;
        logic wr_n;
        logic ub_n;
        logic lb_n;
        logic ba0;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{ale: 1'b0, drive: 1'b0, oe_n: 1'b1,
                                  wrh_n: 1'b1, wrl_n: 1'b1, wr_n: 1'b1,
                                  ub_n: 1'b1, lb_n: 1'b1, ba0: 1'b0};

    function automatic logic is_bsel(wmode_t m);
        return (m == WM_BSEL) || (m == WM_BSEL2);
    endfunction

    function automatic ctl_t decode_ctl(phase_t ph, logic is_wr, wmode_t m, logic lsb);
        ctl_t c;
        c = CTL_IDLE;
        if (ph != PH_IDLE) begin
            c.ba0 = is_bsel(m) & lsb;
        end
        case (ph)
            PH_ADDR: begin
                c.ale   = 1'b1;
                c.drive = 1'b1;
            end
            PH_DATA: begin
                if (!is_wr) begin
                    c.oe_n = 1'b0;
                    c.ub_n = 1'b0;
                    c.lb_n = 1'b0;
                end else begin
                    c.drive = 1'b1;
                    case (m)
                        WM_BYTE: begin
                            if (lsb) c.wrh_n = 1'b0;
                            else     c.wrl_n = 1'b0;
                        end
                        WM_WORD: begin
                            c.wr_n = 1'b0;
                            c.ub_n = 1'b0;
                            c.lb_n = 1'b0;
                        end
                        default: begin
                            c.wr_n = 1'b0;
                            if (lsb) c.ub_n = 1'b0;
                            else     c.lb_n = 1'b0;
                        end
                    endcase
                end
            end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mxbus_seq.sv
module mxbus_seq
    import mxbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    localparam int BYTE_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BYTE_W-1:0] req_wdata,
    input  logic [1:0]        req_mode,
    input  logic              sleep_i,
    output phase_t            phase,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [BYTE_W-1:0] cur_wdata,
    output logic              cur_wr,
    output wmode_t            cur_mode
);

    logic accept;
    assign accept = (phase == PH_IDLE) && !sleep_i && (req_rd || req_wr);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cur_addr  <= '0;
            cur_wdata <= '0;
            cur_wr    <= 1'b0;
            cur_mode  <= WM_BYTE;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        phase     <= PH_ADDR;
                        cur_addr  <= req_addr;
                        cur_wdata <= req_wdata;
                        cur_wr    <= req_wr & ~req_rd;
                        cur_mode  <= wmode_t'(req_mode);
                    end
                end
                PH_ADDR: phase <= PH_TURN;
                PH_TURN: phase <= PH_DATA;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    p_addr_to_turn_r2: assert property (@(posedge clk) disable iff (rst)
        phase == PH_ADDR |=> phase == PH_TURN);

    p_turn_to_data_r3: assert property (@(posedge clk) disable iff (rst)
        phase == PH_TURN |=> phase == PH_DATA);

    p_addr_held_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TURN || phase == PH_DATA) |-> $stable(cur_addr));

    p_sleep_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && sleep_i) |=> phase == PH_IDLE);

endmodule

// File: rtl/mxbus_strobe.sv
module mxbus_strobe
    import mxbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    localparam int BYTE_W = DATA_W / 2,
    localparam int HI_W   = ADDR_W - DATA_W
) (
    input  phase_t            phase,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [BYTE_W-1:0] cur_wdata,
    input  logic              cur_wr,
    input  wmode_t            cur_mode,
    output ctl_t              ctl,
    output logic [DATA_W-1:0] ad_out,
    output logic [HI_W-1:0]   addr_hi
);

    always_comb begin
        ctl = decode_ctl(phase, cur_wr, cur_mode, cur_addr[0]);
        case (phase)
            PH_ADDR: ad_out = cur_addr[DATA_W-1:0];
            PH_DATA: ad_out = cur_wr ? {2{cur_wdata}} : '0;
            default: ad_out = '0;
        endcase
        addr_hi = (phase != PH_IDLE) ? cur_addr[ADDR_W-1:DATA_W] : '0;
    end

    always_comb begin
        a_strobe_excl_r6: assert ($onehot0({~ctl.wrh_n, ~ctl.wrl_n, ~ctl.wr_n, ~ctl.oe_n}));
    end

endmodule

// File: rtl/mxbus_capture.sv
module mxbus_capture
    import mxbus_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_t            phase,
    input  logic              cur_wr,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            done    <= 1'b0;
        end else begin
            done <= (phase == PH_DATA);
            if (phase == PH_DATA && !cur_wr) begin
                rd_data <= ad_in;
            end
        end
    end

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> phase == PH_IDLE);

endmodule

// File: rtl/mxbus_ctrl.sv
module mxbus_ctrl
    import mxbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    localparam int BYTE_W = DATA_W / 2,
    localparam int HI_W   = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BYTE_W-1:0] req_wdata,
    input  logic [1:0]        wr_mode,
    input  logic              sleep_i,
    input  logic [DATA_W-1:0] bus_ad_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic [DATA_W-1:0] bus_ad_out,
    output logic              bus_ad_en,
    output logic [HI_W-1:0]   addr_hi,
    output logic              ale,
    output logic              oe_n,
    output logic              ce_n,
    output logic              wrh_n,
    output logic              wrl_n,
    output logic              wr_n,
    output logic              ub_n,
    output logic              lb_n,
    output logic              ba0
);

    phase_t            phase;
    logic [ADDR_W-1:0] cur_addr;
    logic [BYTE_W-1:0] cur_wdata;
    logic              cur_wr;
    wmode_t            cur_mode;
    ctl_t              ctl;

    mxbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_rd    (req_rd),
        .req_wr    (req_wr),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_mode  (wr_mode),
        .sleep_i   (sleep_i),
        .phase     (phase),
        .cur_addr  (cur_addr),
        .cur_wdata (cur_wdata),
        .cur_wr    (cur_wr),
        .cur_mode  (cur_mode)
    );

    mxbus_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strobe (
        .phase     (phase),
        .cur_addr  (cur_addr),
        .cur_wdata (cur_wdata),
        .cur_wr    (cur_wr),
        .cur_mode  (cur_mode),
        .ctl       (ctl),
        .ad_out    (bus_ad_out),
        .addr_hi   (addr_hi)
    );

    mxbus_capture #(.DATA_W(DATA_W)) u_capture (
        .clk     (clk),
        .rst     (rst),
        .phase   (phase),
        .cur_wr  (cur_wr),
        .ad_in   (bus_ad_in),
        .rd_data (rd_data),
        .done    (done)
    );

    assign bus_ad_en = ctl.drive;
    assign ale       = ctl.ale;
    assign oe_n      = ctl.oe_n;
    assign wrh_n     = ctl.wrh_n;
    assign wrl_n     = ctl.wrl_n;
    assign wr_n      = ctl.wr_n;
    assign ub_n      = ctl.ub_n;
    assign lb_n      = ctl.lb_n;
    assign ba0       = ctl.ba0;
    assign ce_n      = ~((phase != PH_IDLE) & ~sleep_i);

    p_turn_released_r3: assert property (@(posedge clk) disable iff (rst)
        ale |=> (!ale && !bus_ad_en && oe_n && wrh_n && wrl_n && wr_n));

    p_read_no_drive_r4: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> (!bus_ad_en && wrh_n && wrl_n && wr_n));

    p_done_after_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        (!oe_n || !wrh_n || !wrl_n || !wr_n) |=> done);

    p_ce_during_addr_r5: assert property (@(posedge clk) disable iff (rst)
        (ale && !sleep_i) |-> !ce_n);

    p_ba0_unused_r6: assert property (@(posedge clk) disable iff (rst)
        (!wrh_n || !wrl_n) |-> !ba0);

    p_ba0_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && !$past(ale)) |-> $stable(ba0));

endmodule

// File: tb/mxbus_ctrl_tb.sv
module mxbus_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_rd, req_wr, sleep_i;
    logic [19:0] req_addr;
    logic [7:0]  req_wdata;
    logic [1:0]  wr_mode;
    logic [15:0] bus_ad_in;
    logic [15:0] rd_data, bus_ad_out;
    logic        done, bus_ad_en, ale, oe_n, ce_n, wrh_n, wrl_n, wr_n, ub_n, lb_n, ba0;
    logic [3:0]  addr_hi;

    int n_chk = 0;
    int n_err = 0;

    logic [15:0] mem    [0:255];
    logic [15:0] shadow [0:255];
    logic [7:0]  lat_idx = 8'd0;

    always #4 clk = ~clk;

    mxbus_ctrl u_dut (
        .clk(clk), .rst(rst), .req_rd(req_rd), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .wr_mode(wr_mode),
        .sleep_i(sleep_i), .bus_ad_in(bus_ad_in), .rd_data(rd_data),
        .done(done), .bus_ad_out(bus_ad_out), .bus_ad_en(bus_ad_en),
        .addr_hi(addr_hi), .ale(ale), .oe_n(oe_n), .ce_n(ce_n),
        .wrh_n(wrh_n), .wrl_n(wrl_n), .wr_n(wr_n), .ub_n(ub_n),
        .lb_n(lb_n), .ba0(ba0)
    );

    // External latch and memory model
    always @(posedge clk) begin
        if (ale) lat_idx <= bus_ad_out[8:1];
        if (!wrh_n) mem[lat_idx][15:8] <= bus_ad_out[15:8];
        if (!wrl_n) mem[lat_idx][7:0]  <= bus_ad_out[7:0];
        if (!wr_n && !ub_n) mem[lat_idx][15:8] <= bus_ad_out[15:8];
        if (!wr_n && !lb_n) mem[lat_idx][7:0]  <= bus_ad_out[7:0];
    end

    assign bus_ad_in = oe_n ? 16'h0000 : mem[lat_idx];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [8:0] idle_vec();
        return {1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
    endfunction

    task automatic check_idle(input string tag);
        chk({bus_ad_en, ale, done, oe_n, wrh_n, wrl_n, wr_n, ub_n, lb_n} == idle_vec()
            && ce_n && !ba0 && addr_hi == 4'd0, tag,
            {bus_ad_en, ale, done, oe_n, wrh_n, wrl_n, wr_n, ub_n, lb_n, ce_n, ba0, addr_hi},
            {idle_vec(), 1'b1, 1'b0, 4'd0});
    endtask

    // Expected data-cycle strobes {wrh_n, wrl_n, wr_n, ub_n, lb_n, oe_n}
    function automatic logic [5:0] exp_wr_strobes(input logic [1:0] m, input logic a0);
        logic bw, ww, bs;
        bw = (m == 2'b00);
        ww = (m == 2'b01);
        bs = m[1];
        return {!(bw && a0), !(bw && !a0), !(ww || bs),
                !(ww || (bs && a0)), !(ww || (bs && !a0)), 1'b1};
    endfunction

    task automatic access(input logic rd, input logic wr, input logic [19:0] a,
                          input logic [7:0] d, input logic [1:0] m);
        logic        is_wr;
        logic        exp_ba0;
        logic [15:0] exp_rd;
        string       wtag;
        is_wr   = wr && !rd;
        exp_ba0 = m[1] && a[0];
        exp_rd  = shadow[a[8:1]];
        wtag    = (m == 2'b00) ? "R6" : (m == 2'b01) ? "R7" : "R8";
        @(negedge clk);
        req_rd = rd; req_wr = wr; req_addr = a; req_wdata = d; wr_mode = m;
        @(negedge clk);
        req_rd = 1'b0; req_wr = 1'b0;
        // address cycle
        chk(ale && bus_ad_en && bus_ad_out == a[15:0], "R2 address cycle",
            {ale, bus_ad_en, bus_ad_out}, {2'b11, a[15:0]});
        chk(addr_hi == a[19:16], "R2 addr_hi", addr_hi, a[19:16]);
        chk(!ce_n, "R5 ce_n addr", ce_n, 0);
        chk(ba0 == exp_ba0, "R8 ba0 addr", ba0, exp_ba0);
        @(negedge clk);
        // turnaround cycle
        chk(!ale && !bus_ad_en && oe_n && wrh_n && wrl_n && wr_n, "R3 turnaround",
            {ale, bus_ad_en, oe_n, wrh_n, wrl_n, wr_n}, 6'b001111);
        chk(!ce_n && addr_hi == a[19:16] && ba0 == exp_ba0, "R5 R8 turnaround ce/addr/ba0",
            {ce_n, addr_hi, ba0}, {1'b0, a[19:16], exp_ba0});
        @(negedge clk);
        // data cycle
        chk(!ce_n && addr_hi == a[19:16], "R5 ce_n data", {ce_n, addr_hi}, {1'b0, a[19:16]});
        chk(ba0 == exp_ba0, "R8 ba0 data", ba0, exp_ba0);
        if (!is_wr) begin
            chk({wrh_n, wrl_n, wr_n, ub_n, lb_n, oe_n} == 6'b111000 && !bus_ad_en,
                (rd && wr) ? "R10 read priority strobes" : "R4 read strobes",
                {bus_ad_en, wrh_n, wrl_n, wr_n, ub_n, lb_n, oe_n}, 7'b0111000);
        end else begin
            chk({wrh_n, wrl_n, wr_n, ub_n, lb_n, oe_n} == exp_wr_strobes(m, a[0]), wtag,
                {wrh_n, wrl_n, wr_n, ub_n, lb_n, oe_n}, exp_wr_strobes(m, a[0]));
            chk(bus_ad_en && bus_ad_out == {d, d}, wtag, {bus_ad_en, bus_ad_out}, {1'b1, d, d});
            if (m == 2'b01) begin
                shadow[a[8:1]] = {d, d};
            end else if (a[0]) begin
                shadow[a[8:1]][15:8] = d;
            end else begin
                shadow[a[8:1]][7:0] = d;
            end
        end
        @(negedge clk);
        chk(done, "R4 done pulse", done, 1);
        if (!is_wr) begin
            chk(rd_data == exp_rd, (rd && wr) ? "R10 read data" : "R4 read data",
                rd_data, exp_rd);
        end
        chk({bus_ad_en, ale, oe_n, wrh_n, wrl_n, wr_n, ub_n, lb_n, ce_n} == 9'b001111111,
            "R1 released after access", {bus_ad_en, ale, oe_n, wrh_n, wrl_n, wr_n, ub_n, lb_n, ce_n},
            9'b001111111);
        @(negedge clk);
        chk(!done, "R4 done one cycle", done, 0);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < 256; i++) begin
            mem[i]    = 16'(i * 16'h0101) ^ 16'h5A3C;
            shadow[i] = 16'(i * 16'h0101) ^ 16'h5A3C;
        end
        rst = 1'b1; req_rd = 1'b0; req_wr = 1'b0; req_addr = '0;
        req_wdata = '0; wr_mode = 2'b00; sleep_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_idle("R1 reset state");
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1 idle after reset");

        // Directed: every mode, both address parities, read-back
        access(1, 0, 20'hA1234, 8'h00, 2'b00);
        access(0, 1, 20'h30010, 8'h5C, 2'b00);
        access(0, 1, 20'h30011, 8'hE7, 2'b00);
        access(1, 0, 20'h30010, 8'h00, 2'b00);
        access(0, 1, 20'h70022, 8'h9A, 2'b01);
        access(1, 0, 20'h70023, 8'h00, 2'b01);
        access(0, 1, 20'hF0031, 8'h42, 2'b10);
        access(0, 1, 20'hF0040, 8'h17, 2'b11);
        access(1, 0, 20'hF0030, 8'h00, 2'b10);
        access(1, 0, 20'hF0041, 8'h00, 2'b11);
        // Both requests: read wins, memory untouched
        access(1, 1, 20'h50050, 8'hFF, 2'b01);
        access(1, 0, 20'h50050, 8'h00, 2'b00);

        // Sleep: requests ignored, chip enable off
        @(negedge clk);
        sleep_i = 1'b1;
        req_wr = 1'b1; req_addr = 20'h00060; req_wdata = 8'hC3; wr_mode = 2'b01;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(ce_n && !ale && !done && wr_n && !bus_ad_en, "R9 sleep ignores request",
                {ce_n, ale, done, wr_n, bus_ad_en}, 5'b10010);
        end
        req_wr = 1'b0;
        sleep_i = 1'b0;
        access(1, 0, 20'h00060, 8'h00, 2'b00);

        // Constrained random mix
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            logic        rd_b, wr_b;
            r = $urandom();
            rd_b = r[0];
            wr_b = r[1] | ~r[0];
            access(rd_b, wr_b, 20'($urandom()), 8'($urandom()), r[3:2]);
        end

        @(negedge clk);
        check_idle("R1 final idle");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule